// File: doc/BRIEF.md
# Bank State and Command Legality Unit

This block follows the operating state of a single memory bank and decides, cycle by cycle, whether the command type offered to it may issue now. The bank is in one of five states: closed, open, or one of three power-down modes. The three modes are active power-down, precharged power-down with fast exit, and precharged power-down with slow exit. The decision uses four inputs:

- the present state;
- a set of per-command earliest-issue timestamps kept inside the block;
- a busy flag that says an internal command is already pending;
- the per-subarray readiness and activity vectors.

Commands arrive on a valid/ready pair. `req_ready` is the legality verdict for the type currently on `req_type`. It is driven whether or not `req_valid` is high, and it never depends on `req_valid`. A command issues in the cycle where `req_valid` and `req_ready` are both high at the clock edge. In that cycle the state and timestamps update from the cycle counter `now` and the timing inputs. When `req_valid` is high and `req_ready` is low, the requester is being held back. `fail_timing` then reports a bank-timing refusal, and the requester may keep, change or drop its request freely. No state changes without a handshake.

Top module: `bank_cmd_gate`

## Requirements
- R1: After reset the state is closed (code 0) and every stored timestamp is zero. State codes: closed 0, open 1, active power-down 2, fast-exit precharged power-down 3, slow-exit precharged power-down 4.
- R2: While `cmd_busy` is high, `req_ready` is low for every command type.
- R3: Activate (code 0) is legal when the earliest-activate time is not after `now` and the state is not a power-down state. On issue the state becomes open, earliest read and write become now+t_rcd, earliest precharge becomes now+t_ras, and earliest activate becomes now+t_ras+t_rp.
- R4: Read (1), read with auto-precharge (2), write (3) and write with auto-precharge (4) are legal only in the open state once the earliest read (for reads) or earliest write (for writes) time is reached. The auto-precharge forms move the state to closed and raise earliest activate to at least now+t_rp. The plain forms change nothing.
- R5: Precharge (5) and precharge-all (6) need the state closed or open and the earliest-precharge time reached. Precharge-all also needs `sa_ready` high on every subarray whose `sa_active` bit is set. On issue the state becomes closed and earliest activate is raised to at least now+t_rp.
- R6: The power-down commands are active (7), fast-exit (8) and slow-exit (9). Each needs the earliest-power-down time reached, the state closed or open, and all `sa_ready` bits high. The fast-exit and slow-exit forms are refused while open. On issue the state becomes the requested mode and earliest power-up becomes now+t_cke.
- R7: Power-up (10) is legal only in a power-down state, once earliest power-up is reached and with all `sa_ready` bits high. It returns to open from active power-down and to closed from the other two modes. It raises earliest activate to at least now+t_xp and sets earliest power-down to now+t_xp.
- R8: Refresh (11) needs the state closed or open and earliest activate reached. On issue the state is unchanged and earliest activate becomes now+t_rfc.
- R9: Codes 12 to 15 are never legal. `fail_timing` equals `req_valid` and not `req_ready`.
- R10: The state and timestamps change only on a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is offered |
| req_type | input | 4 | Command code (see requirements) |
| req_ready | output | 1 | Offered command type is legal now |
| fail_timing | output | 1 | Offered command refused for bank timing or state |
| cmd_busy | input | 1 | An internal command is already pending |
| now | input | TS_W | Current cycle count |
| t_rcd | input | TIM_W | Activate to read/write delay |
| t_rp | input | TIM_W | Precharge to activate delay |
| t_ras | input | TIM_W | Activate to precharge delay |
| t_cke | input | TIM_W | Minimum power-down dwell |
| t_xp | input | TIM_W | Power-up exit delay |
| t_rfc | input | TIM_W | Refresh to activate delay |
| sa_ready | input | NSA | Per-subarray readiness |
| sa_active | input | NSA | Per-subarray activity |
| bank_state | output | 3 | Current state code |

## Verification
Suppose a state register or a timestamp holds a wrong value. This shows up as a wrong `req_ready` verdict for some command type, and it can stay hidden until that type is offered. A wrong state code appears on `bank_state` one cycle after the faulty handshake. A wrong timestamp shows only at the one cycle where `now` crosses the true boundary. The bench therefore keeps an independent model, offers mixed command types every cycle with short timing values, and compares the verdict, the failure flag and the state on every cycle. This catches such faults at the first cycle in which they become visible.

// File: rtl/bank_pkg.sv
package bank_pkg;
  typedef enum logic [3:0] {
    C_ACT  = 4'd0,  C_RD   = 4'd1,  C_RDA  = 4'd2,  C_WR  = 4'd3,
    C_WRA  = 4'd4,  C_PRE  = 4'd5,  C_PREA = 4'd6,  C_PDA = 4'd7,
    C_PDPF = 4'd8,  C_PDPS = 4'd9,  C_PUP  = 4'd10, C_REF = 4'd11,
    C_X12  = 4'd12, C_X13  = 4'd13, C_X14  = 4'd14, C_X15 = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    S_CLOSED = 3'd0, S_OPEN = 3'd1, S_PDA = 3'd2, S_PDF = 3'd3, S_PDS = 3'd4
  } bstate_e;

  localparam int TS_ACT = 0;
  localparam int TS_RD  = 1;
  localparam int TS_WR  = 2;
  localparam int TS_PRE = 3;
  localparam int TS_PD  = 4;
  localparam int TS_PUP = 5;
  localparam int NTS    = 6;

  function automatic logic is_pd(bstate_e s);
    return (s == S_PDA) || (s == S_PDF) || (s == S_PDS);
  endfunction
endpackage

// File: rtl/bank_timers.sv
module bank_timers
  import bank_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int TIM_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  cmd_e                   cmd,
  input  logic [TS_W-1:0]        now,
  input  logic [TIM_W-1:0]       t_rcd,
  input  logic [TIM_W-1:0]       t_rp,
  input  logic [TIM_W-1:0]       t_ras,
  input  logic [TIM_W-1:0]       t_cke,
  input  logic [TIM_W-1:0]       t_xp,
  input  logic [TIM_W-1:0]       t_rfc,
  output logic [NTS-1:0]         reached
);
  localparam int PADW = TS_W - TIM_W;

  logic [TS_W-1:0] ts_q [NTS];
  logic [TS_W-1:0] ts_d [NTS];
  logic [TS_W-1:0] e_rcd, e_rp, e_ras, e_cke, e_xp, e_rfc;

  assign e_rcd = {{PADW{1'b0}}, t_rcd};
  assign e_rp  = {{PADW{1'b0}}, t_rp};
  assign e_ras = {{PADW{1'b0}}, t_ras};
  assign e_cke = {{PADW{1'b0}}, t_cke};
  assign e_xp  = {{PADW{1'b0}}, t_xp};
  assign e_rfc = {{PADW{1'b0}}, t_rfc};

  function automatic logic [TS_W-1:0] later(logic [TS_W-1:0] a, logic [TS_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    for (int i = 0; i < NTS; i++) ts_d[i] = ts_q[i];
    unique case (cmd)
      C_ACT: begin
        ts_d[TS_RD]  = now + e_rcd;
        ts_d[TS_WR]  = now + e_rcd;
        ts_d[TS_PRE] = now + e_ras;
        ts_d[TS_ACT] = now + e_ras + e_rp;
      end
      C_RDA, C_WRA, C_PRE, C_PREA:
        ts_d[TS_ACT] = later(ts_q[TS_ACT], now + e_rp);
      C_PDA, C_PDPF, C_PDPS:
        ts_d[TS_PUP] = now + e_cke;
      C_PUP: begin
        ts_d[TS_ACT] = later(ts_q[TS_ACT], now + e_xp);
        ts_d[TS_PD]  = now + e_xp;
      end
      C_REF:
        ts_d[TS_ACT] = now + e_rfc;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTS; i++) ts_q[i] <= '0;
    end else if (fire) begin
      for (int i = 0; i < NTS; i++) ts_q[i] <= ts_d[i];
    end
  end

  for (genvar g = 0; g < NTS; g++) begin : g_cmp
    assign reached[g] = (ts_q[g] <= now);
  end

  // R10: timestamps move only on a handshake
  p_ts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(ts_q[TS_ACT]) && $stable(ts_q[TS_PUP]));
endmodule

// File: rtl/bank_fsm.sv
module bank_fsm
  import bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  cmd_e    cmd,
  output bstate_e state
);
  bstate_e nxt;

  always_comb begin
    nxt = state;
    unique case (cmd)
      C_ACT:                      nxt = S_OPEN;
      C_RDA, C_WRA, C_PRE, C_PREA: nxt = S_CLOSED;
      C_PDA:                      nxt = S_PDA;
      C_PDPF:                     nxt = S_PDF;
      C_PDPS:                     nxt = S_PDS;
      C_PUP:                      nxt = (state == S_PDA) ? S_OPEN : S_CLOSED;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= S_CLOSED;
    else if (fire) state <= nxt;
  end

  p_act_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd == C_ACT |=> state == S_OPEN);
  p_pre_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (cmd == C_PRE || cmd == C_PREA) |=> state == S_CLOSED);
  p_ref_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd == C_REF |=> $stable(state));
  p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(state));
endmodule

// File: rtl/bank_legality.sv
module bank_legality
  import bank_pkg::*;
#(
  parameter int NSA = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cmd_e                cmd,
  input  bstate_e             state,
  input  logic                busy,
  input  logic [NTS-1:0]      reached,
  input  logic [NSA-1:0]      sa_ready,
  input  logic [NSA-1:0]      sa_active,
  output logic                legal
);
  logic all_sa, active_sa, live, pd;

  assign all_sa    = &sa_ready;
  assign active_sa = &(sa_ready | ~sa_active);
  assign live      = (state == S_CLOSED) || (state == S_OPEN);
  assign pd        = is_pd(state);

  always_comb begin
    legal = 1'b0;
    unique case (cmd)
      C_ACT:         legal = reached[TS_ACT] && !pd;
      C_RD, C_RDA:   legal = reached[TS_RD] && state == S_OPEN;
      C_WR, C_WRA:   legal = reached[TS_WR] && state == S_OPEN;
      C_PRE:         legal = reached[TS_PRE] && live;
      C_PREA:        legal = reached[TS_PRE] && live && active_sa;
      C_PDA:         legal = reached[TS_PD] && live && all_sa;
      C_PDPF, C_PDPS: legal = reached[TS_PD] && state == S_CLOSED && all_sa;
      C_PUP:         legal = reached[TS_PUP] && pd && all_sa;
      C_REF:         legal = reached[TS_ACT] && live;
      default:       legal = 1'b0;
    endcase
    if (busy) legal = 1'b0;
  end

  p_busy_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !legal);
  p_rdwr_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    legal && (cmd inside {C_RD, C_RDA, C_WR, C_WRA}) |-> state == S_OPEN);
  p_pup_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    legal && cmd == C_PUP |-> pd);
  p_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd inside {C_X12, C_X13, C_X14, C_X15} |-> !legal);
endmodule

// File: rtl/bank_cmd_gate.sv
module bank_cmd_gate
  import bank_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int TIM_W = 8,
  parameter int NSA   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_type,
  output logic             req_ready,
  output logic             fail_timing,
  input  logic             cmd_busy,
  input  logic [TS_W-1:0]  now,
  input  logic [TIM_W-1:0] t_rcd,
  input  logic [TIM_W-1:0] t_rp,
  input  logic [TIM_W-1:0] t_ras,
  input  logic [TIM_W-1:0] t_cke,
  input  logic [TIM_W-1:0] t_xp,
  input  logic [TIM_W-1:0] t_rfc,
  input  logic [NSA-1:0]   sa_ready,
  input  logic [NSA-1:0]   sa_active,
  output logic [2:0]       bank_state
);
  cmd_e           cmd;
  bstate_e        st;
  logic [NTS-1:0] reached;
  logic           fire;

  assign cmd  = cmd_e'(req_type);
  assign fire = req_valid && req_ready;

  bank_timers #(.TS_W(TS_W), .TIM_W(TIM_W)) u_tim (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cmd), .now(now),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_cke(t_cke),
    .t_xp(t_xp), .t_rfc(t_rfc), .reached(reached)
  );

  bank_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cmd), .state(st)
  );

  bank_legality #(.NSA(NSA)) u_leg (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .state(st), .busy(cmd_busy),
    .reached(reached), .sa_ready(sa_ready), .sa_active(sa_active),
    .legal(req_ready)
  );

  assign fail_timing = req_valid && !req_ready;
  assign bank_state  = st;

  p_pd_no_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state inside {3'd2, 3'd3, 3'd4}) && req_type == 4'd0 |-> !req_ready);
  p_pdp_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_state == 3'd1 && (req_type == 4'd8 || req_type == 4'd9) |-> !req_ready);
endmodule

// File: tb/bank_cmd_gate_test.sv
module bank_cmd_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_type = '0;
  logic        req_ready, fail_timing;
  logic        cmd_busy = 1'b0;
  logic [15:0] now = '0;
  logic [7:0]  t_rcd = 8'd3, t_rp = 8'd3, t_ras = 8'd6, t_cke = 8'd4, t_xp = 8'd2, t_rfc = 8'd9;
  logic [3:0]  sa_ready = 4'hF, sa_active = 4'h0;
  logic [2:0]  bank_state;

  int n_chk = 0, n_bad = 0;
  int m_st = 0;
  int m_ts[6] = '{default: 0};
  bit done = 0;

  always #10 clk = ~clk;

  bank_cmd_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_ready(req_ready), .fail_timing(fail_timing), .cmd_busy(cmd_busy),
    .now(now), .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_cke(t_cke),
    .t_xp(t_xp), .t_rfc(t_rfc), .sa_ready(sa_ready), .sa_active(sa_active),
    .bank_state(bank_state)
  );

  function automatic string tag_of(int c);
    if (cmd_busy) return "R2";
    case (c)
      0: return "R3";
      1, 2, 3, 4: return "R4";
      5, 6: return "R5";
      7, 8, 9: return "R6";
      10: return "R7";
      11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at now=%0d", tag, act, exp, now);
    end
  endtask

  function automatic bit model_ready(int c, int t);
    bit live = (m_st == 0 || m_st == 1);
    bit pd = (m_st >= 2);
    bit all = (sa_ready == 4'hF);
    if (cmd_busy) return 0;
    case (c)
      0: return m_ts[0] <= t && !pd;
      1, 2: return m_ts[1] <= t && m_st == 1;
      3, 4: return m_ts[2] <= t && m_st == 1;
      5: return m_ts[3] <= t && live;
      6: return m_ts[3] <= t && live && ((sa_ready | ~sa_active) == 4'hF);
      7: return m_ts[4] <= t && live && all;
      8, 9: return m_ts[4] <= t && m_st == 0 && all;
      10: return m_ts[5] <= t && pd && all;
      11: return m_ts[0] <= t && live;
      default: return 0;
    endcase
  endfunction

  task automatic model_issue(int c, int t);
    case (c)
      0: begin m_st = 1; m_ts[1] = t + t_rcd; m_ts[2] = t + t_rcd;
               m_ts[3] = t + t_ras; m_ts[0] = t + t_ras + t_rp; end
      2, 4, 5, 6: begin m_st = 0; if (t + t_rp > m_ts[0]) m_ts[0] = t + t_rp; end
      7, 8, 9: begin m_st = c - 5; m_ts[5] = t + t_cke; end
      10: begin m_st = (m_st == 2) ? 1 : 0;
                if (t + t_xp > m_ts[0]) m_ts[0] = t + t_xp; m_ts[4] = t + t_xp; end
      11: m_ts[0] = t + t_rfc;
      default: ;
    endcase
  endtask

  // one cycle: drive at negedge, compare, advance model for the coming edge
  task automatic step(bit v, int c, bit busy, logic [3:0] sr, logic [3:0] sa);
    bit er;
    @(negedge clk);
    now = now + 16'd1;
    req_valid = v; req_type = 4'(c); cmd_busy = busy; sa_ready = sr; sa_active = sa;
    #2;
    check(bank_state == 3'(m_st), "R10 state", int'(bank_state), m_st);
    er = model_ready(c, int'(now));
    check(req_ready == er, tag_of(c), int'(req_ready), int'(er));
    check(fail_timing == (v && !er), "R9 fail_timing", int'(fail_timing), int'(v && !er));
    if (v && er) model_issue(c, int'(now));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state closed, all timestamps at zero
    #2 check(bank_state == 3'd0, "R1 reset state", int'(bank_state), 0);
    step(1'b0, 10, 0, 4'hF, 4'h0);           // R7: power-up illegal when closed
    step(1'b1, 1, 0, 4'hF, 4'h0);            // R4: read illegal when closed
    step(1'b1, 0, 1, 4'hF, 4'h0);            // R2: busy blocks activate
    step(1'b1, 0, 0, 4'hF, 4'h0);            // R3: activate issues
    step(1'b1, 1, 0, 4'hF, 4'h0);            // R4: read too early
    step(1'b1, 8, 0, 4'hF, 4'h0);            // R6: fast-exit refused while open
    repeat (3) step(1'b1, 3, 0, 4'hF, 4'h0); // R4: write once t_rcd met
    step(1'b1, 13, 0, 4'hF, 4'h0);           // R9: unknown code
    repeat (4) step(1'b1, 6, 0, 4'h5, 4'h6); // R5: precharge-all blocked by active subarray
    repeat (4) step(1'b1, 6, 0, 4'h7, 4'h6); // R5: precharge-all with active ones ready
    step(1'b1, 7, 0, 4'hF, 4'h0);            // R6: active power-down from closed
    repeat (6) step(1'b1, 10, 0, 4'hF, 4'h0);// R7: power-up after t_cke
    step(1'b1, 11, 0, 4'hF, 4'h0);           // R8: refresh
    for (int i = 0; i < 4000; i++) begin
      int c = (($urandom % 8) == 0) ? int'($urandom % 16) : int'($urandom % 12);
      bit b = (($urandom % 10) == 0);
      logic [3:0] sr = (($urandom % 5) == 0) ? 4'($urandom) : 4'hF;
      step(($urandom % 4) != 0, c, b, sr, 4'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule